// File: doc/BRIEF.md
# PPS Period Measurement and Frequency Error Tracker

The block measures how many cycles of its own clock fit between successive rising edges of a one-pulse-per-second reference. A plausible measurement becomes a signed frequency error against the expected count. That error then drives a train of single-step adjustment requests for a separate frequency actuator. Requests carry a direction and are spread evenly across the second. A lock indication reports when the error has stayed small for a run of consecutive measurements.

The reference pulse arrives asynchronously and is synchronised inside the block. Everything else runs in the one local clock domain. The expected count per second (`NOMINAL`), the lock threshold, the lock run length and the minimum spacing between step requests are parameters.

Top module: `pps_err_tracker`

## Requirements
- R1: `pps_i` passes through a two-flop synchroniser and an edge detector. If `pps_i` is high before clock edge k, `err_o`, `meas_valid_o` and `lock_o` reflect that measurement from edge k+2. `meas_valid_o` is high for exactly one cycle.
- R2: A measurement equals the number of clock cycles between two consecutive detected rising edges of the reference.
- R3: The cycle counter saturates at 2^CNT_W-1 instead of wrapping, with CNT_W = clog2(NOMINAL + NOMINAL/100 + 2) + 1. For NOMINAL=1000 this gives 11 bits, so the counter holds at 2047.
- R4: The first detected edge after reset only starts the counter. It produces no measurement, no `meas_valid_o` and no change to the error.
- R5: A measurement in the inclusive window [NOMINAL - NOMINAL/100, NOMINAL + NOMINAL/100] is accepted. On acceptance, `err_o` becomes NOMINAL minus the measurement, as a two's-complement value of CNT_W+1 bits, and `meas_valid_o` pulses.
- R6: A measurement outside the window is discarded. `err_o` keeps its value, `meas_valid_o` stays low and `lock_o` is cleared.
- R7: `lock_o` rises on the LOCK_RUN-th consecutive accepted measurement whose error magnitude is at most LOCK_THR. It drops on the first accepted measurement whose magnitude exceeds LOCK_THR.
- R8: `step_dir_o` is 1 when `err_o` is positive, which requests faster steps, and 0 otherwise.
- R9: While `err_o` holds a value e, the block issues |e| one-cycle `step_o` strobes per NOMINAL cycles, to within one.
- R10: Two `step_o` strobes are never closer than MIN_GAP cycles apart.
- R11: No `step_o` strobes are issued while `err_o` is zero, and this includes the time after reset.
- R12: After reset, `err_o` is 0 and `meas_valid_o`, `step_o` and `lock_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock being measured |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Asynchronous one-pulse-per-second reference |
| err_o | output | CNT_W+1 | Signed error, NOMINAL minus the last accepted measurement |
| meas_valid_o | output | 1 | One-cycle pulse when a measurement is accepted |
| step_dir_o | output | 1 | Step direction, 1 = speed up |
| step_o | output | 1 | One-cycle fine-step request |
| lock_o | output | 1 | Error has stayed within threshold for the required run |

## Verification
The bench builds the block with NOMINAL=1000, which gives a ±10-count window, an 11-bit counter and a full simulated second of only 1000 cycles. At this size a sweep of every reference period from 985 to 1015 crosses both window edges. Several complete seconds can then be observed per error value to count step strobes. A 3048-cycle gap exceeds the counter range by exactly one nominal second, so a wrapping counter would read a perfect 1000 while the saturating one must reject it. The defaults LOCK_THR=2, LOCK_RUN=4 and MIN_GAP=12 keep lock runs and spacing short enough to provoke with a few pulses.

// File: rtl/pps_trk_pkg.sv
package pps_trk_pkg;
  // counter width with headroom so the +1% window edge never saturates
  function automatic int unsigned cnt_width(input int unsigned nominal);
    return $clog2(nominal + nominal / 100 + 2) + 1;
  endfunction
endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pps_i};
  end

  assign rise_o = sync_q[1] & ~sync_q[2];

  a_r1_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pps_period_meas.sv
module pps_period_meas #(
  parameter int unsigned NOMINAL = 1000,
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned ERR_W   = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rise_i,
  output logic                    cap_o,
  output logic                    in_win_o,
  output logic signed [ERR_W-1:0] new_err_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    valid_o
);
  localparam int unsigned TOL = NOMINAL / 100;
  localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(NOMINAL - TOL);
  localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(NOMINAL + TOL);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [ERR_W-1:0] NOM_S = ERR_W'(NOMINAL);

  logic [CNT_W-1:0]        cnt_q;
  logic                    armed_q;
  logic signed [ERR_W-1:0] err_q;
  logic                    valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= CNT_W'(1);
      armed_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cap_o     = rise_i & armed_q;
  assign in_win_o  = (cnt_q >= WIN_LO) && (cnt_q <= WIN_HI);
  assign new_err_o = NOM_S - $signed({1'b0, cnt_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap_o & in_win_o;
      if (cap_o && in_win_o) err_q <= new_err_o;
    end
  end

  assign err_o   = err_q;
  assign valid_o = valid_q;

  a_r3_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !rise_i) |=> (cnt_q == CNT_MAX));
  a_r6_reject_holds_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && !in_win_o) |=> ($stable(err_q) && !valid_q));
  a_r1_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r4_first_edge_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !armed_q) |=> !valid_q);
endmodule

// File: rtl/pps_lock_det.sv
module pps_lock_det #(
  parameter int unsigned ERR_W    = 12,
  parameter int unsigned LOCK_THR = 2,
  parameter int unsigned LOCK_RUN = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic                    in_win_i,
  input  logic signed [ERR_W-1:0] new_err_i,
  output logic                    lock_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);

  logic [RUN_W-1:0] run_q;
  logic [ERR_W-1:0] mag;
  logic             good;

  assign mag  = new_err_i[ERR_W-1] ? ERR_W'(-new_err_i) : ERR_W'(new_err_i);
  assign good = in_win_i && (mag <= ERR_W'(LOCK_THR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= '0;
    else if (cap_i) run_q <= !good ? '0 : (run_q == RUN_FULL) ? run_q : run_q + RUN_W'(1);
  end

  assign lock_o = (run_q == RUN_FULL);

  a_r6_reject_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !in_win_i) |=> !lock_o);
  a_r7_lock_needs_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(cap_i));
endmodule

// File: rtl/pps_step_sched.sv
module pps_step_sched #(
  parameter int unsigned NOMINAL = 1000,
  parameter int unsigned ERR_W   = 12,
  parameter int unsigned MIN_GAP = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  output logic                    step_o,
  output logic                    dir_o
);
  localparam int unsigned ACC_W = ERR_W + 1;
  localparam int unsigned GAP_W = $clog2(MIN_GAP);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(MIN_GAP - 1);
  localparam logic [ACC_W-1:0] NOM_A    = ACC_W'(NOMINAL);

  logic [ACC_W-1:0] acc_q, sum;
  logic [ERR_W-1:0] mag;
  logic [GAP_W-1:0] gap_q;
  logic             pend_q, step_q, zero, carry, gap_ok, issue;

  assign zero   = (err_i == '0);
  assign mag    = err_i[ERR_W-1] ? ERR_W'(-err_i) : ERR_W'(err_i);
  assign sum    = acc_q + ACC_W'(mag);
  assign carry  = !zero && (sum >= NOM_A);
  assign gap_ok = (gap_q == GAP_LAST);
  assign issue  = pend_q && gap_ok && !zero;

  // rate accumulator: one carry per NOMINAL/|err| cycles on average
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
    end else if (zero) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      acc_q  <= carry ? sum - NOM_A : sum;
      pend_q <= carry | (pend_q & ~issue);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= GAP_LAST;
      step_q <= 1'b0;
    end else begin
      step_q <= issue;
      if (issue)       gap_q <= '0;
      else if (!gap_ok) gap_q <= gap_q + GAP_W'(1);
    end
  end

  assign step_o = step_q;
  assign dir_o  = !err_i[ERR_W-1] && !zero;

  // independent spacing monitor
  localparam int unsigned SIN_W = $clog2(MIN_GAP + 1);
  localparam logic [SIN_W-1:0] SIN_MAX = SIN_W'(MIN_GAP);
  logic [SIN_W-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= SIN_MAX;
    else if (step_q)          since_q <= SIN_W'(1);
    else if (since_q != SIN_MAX) since_q <= since_q + SIN_W'(1);
  end

  a_r10_min_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |-> (since_q == SIN_MAX));
  a_r11_quiet_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(zero) && $past(zero, 2)) |-> !step_q);
  a_r10_step_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |=> !step_q);
endmodule

// File: rtl/pps_err_tracker.sv
module pps_err_tracker #(
  parameter int unsigned NOMINAL  = 10_000_000,
  parameter int unsigned LOCK_THR = 2,
  parameter int unsigned LOCK_RUN = 4,
  parameter int unsigned MIN_GAP  = 12,
  localparam int unsigned CNT_W   = pps_trk_pkg::cnt_width(NOMINAL),
  localparam int unsigned ERR_W   = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pps_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    meas_valid_o,
  output logic                    step_dir_o,
  output logic                    step_o,
  output logic                    lock_o
);
  logic                    rise, cap, in_win;
  logic signed [ERR_W-1:0] new_err, err;

  pps_sync_edge u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pps_i(pps_i), .rise_o(rise)
  );

  pps_period_meas #(.NOMINAL(NOMINAL), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .cap_o(cap),
    .in_win_o(in_win), .new_err_o(new_err), .err_o(err), .valid_o(meas_valid_o)
  );

  pps_lock_det #(.ERR_W(ERR_W), .LOCK_THR(LOCK_THR), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .in_win_i(in_win),
    .new_err_i(new_err), .lock_o(lock_o)
  );

  pps_step_sched #(.NOMINAL(NOMINAL), .ERR_W(ERR_W), .MIN_GAP(MIN_GAP)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_i(err), .step_o(step_o), .dir_o(step_dir_o)
  );

  assign err_o = err;

  a_r5_valid_follows_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_valid_o |-> $past(rise));
  a_r8_dir_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_dir_o |-> (err_o > 0));
endmodule

// File: tb/tb_pps_err_tracker.sv
module tb_pps_err_tracker;
  localparam int NOM = 1000;
  localparam int MAXC = 2047;

  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0;
  logic signed [11:0] err;
  logic valid, dir, step, lock;

  always #2 clk = ~clk;

  pps_err_tracker #(.NOMINAL(NOM), .LOCK_THR(2), .LOCK_RUN(4), .MIN_GAP(12)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .err_o(err),
    .meas_valid_o(valid), .step_dir_o(dir), .step_o(step), .lock_o(lock)
  );

  int errs = 0, checks = 0;
  int exp_err = 0, run = 0, armed = 0, last_gap = 0;
  int step_cnt = 0, since = 100000, min_since = 100000, snap = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    since++;
    if (step) begin
      step_cnt++;
      if (since < min_since) min_since = since;
      since = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_pulse(input int gap_next);
    int meas; bit acc; int mag;
    pps = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    acc = 0;
    if (armed != 0) begin
      meas = (last_gap > MAXC) ? MAXC : last_gap;
      acc = (meas >= NOM - 10) && (meas <= NOM + 10);
      if (acc) begin
        exp_err = NOM - meas;
        mag = exp_err < 0 ? -exp_err : exp_err;
        run = (mag <= 2) ? ((run < 4) ? run + 1 : 4) : 0;
      end else run = 0;
      chk(valid == acc, "R5/R6 valid", valid, acc);
    end else begin
      chk(valid == 1'b0, "R4 first edge", valid, 0);
    end
    chk(int'(err) == exp_err, "R2/R3/R5/R6 err", int'(err), exp_err);
    chk(lock == (run >= 4), "R7 lock", lock, run >= 4);
    chk(dir == (exp_err > 0), "R8 dir", dir, exp_err > 0);
    @(negedge clk); #1;
    chk(valid == 1'b0, "R1 valid width", valid, 0);
    snap = step_cnt;
    armed = 1;
    last_gap = gap_next;
    @(negedge clk);
    pps = 1'b0;
    repeat (gap_next - 5) @(negedge clk);
  endtask

  initial begin
    int seq[$];
    int s0, e, mag;
    repeat (3) @(negedge clk);
    #1;
    chk(err == 0 && !valid && !step && !lock, "R12 reset", {err, valid, step, lock}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (NOM) @(negedge clk);
    chk(step_cnt == 0, "R11 idle after reset", step_cnt, 0);
    do_pulse(NOM);  // R4: arms only
    for (int p = 985; p <= 1015; p++) do_pulse(p);  // R5/R6 window edges
    seq = '{1001, 999, 1002, 1000, 1003, 1000, 1000, 1001, 999, 1020, 1000, 3048, 1000, 1000};
    foreach (seq[i]) do_pulse(seq[i]);  // R7 lock runs, R3 saturation
    // R9/R11 step rate per error value
    foreach (seq[i]) ;
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: e = 5;  1: e = -7; 2: e = 1;
        3: e = 10; 4: e = -10; default: e = 0;
      endcase
      do_pulse(NOM - e); do_pulse(NOM - e); do_pulse(NOM - e);
      s0 = snap;
      do_pulse(NOM - e);
      mag = e < 0 ? -e : e;
      if (e == 0) chk(snap - s0 == 0, "R11 no steps at zero", snap - s0, 0);
      else chk((snap - s0 >= mag - 1) && (snap - s0 <= mag + 1), "R9 step rate", snap - s0, mag);
    end
    chk(min_since >= 12, "R10 spacing", min_since, 12);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule